// File: doc/BRIEF.md
# Four-Tap FIR Multiply-Add Slice

This block computes one four-tap section of a finite impulse response filter. Four 18-bit sample registers sit in a row. Each register feeds one multiplier, and the other operand of that multiplier is a registered coefficient taken from its own parallel input. The four products are combined in two levels. Taps 0 and 1 meet in one first-level stage, and taps 2 and 3 meet in another. Each of these stages adds or subtracts under its own run-time control. A final adder then sums the two partial results into a registered output.

In streaming use, samples enter at tap 0 and move one tap per enabled clock. Tap k therefore holds the sample that is k positions older. The oldest sample leaves on a chain output, which can drive the chain input of a further slice. A per-tap select makes any sample register load the shared parallel input instead of its upstream neighbour. The delay line can therefore be reloaded in the middle of a stream without extra cycles.

One control decides whether the sample operands are signed, and a second control does the same for the coefficients. When both controls are 0 the arithmetic is unsigned. An optional register between the multipliers and the adder tree shortens the critical path. The add/subtract controls are delayed through that register so that they stay aligned with their products.

Top module: `fir4_slice`

## Requirements
- R1: While `rst_n` is low, every register clears at once. `sum_out` and `chain_out` then read 0.
- R2: On an enabled edge, tap 0 loads `chain_in` when `src_sel[0]` is 1 and loads `smp_in` when it is 0.
- R3: On an enabled edge, tap k (k = 1..3) loads tap k-1 when `src_sel[k]` is 1 and loads `smp_in` when it is 0. Each coefficient register k loads `coef_k`.
- R4: `chain_out` always shows the content of tap 3.
- R5: A sample operand is two's complement when `a_signed` is 1 and unsigned when it is 0. `b_signed` does the same for the coefficients. A product is signed whenever either operand is signed. Both controls are captured together with the operands.
- R6: The lower stage gives p0+p1 when `add_lo` is 1 and p0-p1 when it is 0. The upper stage gives p2+p3 or p2-p3 under `add_hi` in the same way. Both controls are captured with the operands.
- R7: `sum_out` is the sum of both first-level results. It is 2W+3 bits wide, so no combination of operands or modes can overflow it.
- R8: Values captured at an enabled edge reach `sum_out` after PIPE+1 further enabled edges. PIPE is 0 or 1.
- R9: While `en` is low, no register changes. `sum_out` and `chain_out` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous clear, active low |
| en | input | 1 | Clock enable for every register |
| smp_in | input | W | Parallel sample input |
| chain_in | input | W | Chain input from the previous slice |
| src_sel | input | 4 | Per-tap source: 1 = chain or neighbour, 0 = parallel |
| coef0 | input | W | Coefficient of tap 0 |
| coef1 | input | W | Coefficient of tap 1 |
| coef2 | input | W | Coefficient of tap 2 |
| coef3 | input | W | Coefficient of tap 3 |
| a_signed | input | 1 | Sample operands are signed |
| b_signed | input | 1 | Coefficient operands are signed |
| add_lo | input | 1 | 1 = p0+p1, 0 = p0-p1 |
| add_hi | input | 1 | 1 = p2+p3, 0 = p2-p3 |
| chain_out | output | W | Tap 3 content, for the next slice |
| sum_out | output | 2W+3 | Registered filter sum |

## Verification
The bench sweeps all sixteen combinations of the two sign controls and the two add/subtract controls. Under each combination it runs a stream that starts with the extreme values 0x20000 and 0x3FFFF, so that a missing sign extension, a wrong operand sign or a swapped add and subtract changes the sum. Inside each stream the select pattern changes from plain shifting to a full parallel reload, then to mixed selects, then to loading tap 0 from the chain input. These patterns separate the neighbour path from the parallel path tap by tap. A stalled cycle with changed inputs shows whether any register ignores the enable.

// File: rtl/fir4_slice.sv
`timescale 1ns/1ps
module fir4_slice #(
  parameter int W    = 18,
  parameter bit PIPE = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [W-1:0]   smp_in,
  input  logic [W-1:0]   chain_in,
  input  logic [3:0]     src_sel,
  input  logic [W-1:0]   coef0,
  input  logic [W-1:0]   coef1,
  input  logic [W-1:0]   coef2,
  input  logic [W-1:0]   coef3,
  input  logic           a_signed,
  input  logic           b_signed,
  input  logic           add_lo,
  input  logic           add_hi,
  output logic [W-1:0]   chain_out,
  output logic [2*W+2:0] sum_out
);
  localparam int P = 2*W + 1;
  localparam int S = 2*W + 3;

  logic [W-1:0] smp_q [4];
  logic [W-1:0] cof_q [4];
  logic [W-1:0] upstream [4];
  logic [W-1:0] cof_in [4];
  logic sa_q, sb_q, ad0_q, ad1_q;

  assign cof_in = '{coef0, coef1, coef2, coef3};

  always_comb begin
    upstream[0] = chain_in;
    for (int k = 1; k < 4; k++) upstream[k] = smp_q[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) begin
        smp_q[k] <= '0;
        cof_q[k] <= '0;
      end
      {sa_q, sb_q, ad0_q, ad1_q} <= '0;
    end else if (en) begin
      for (int k = 0; k < 4; k++) begin
        smp_q[k] <= src_sel[k] ? upstream[k] : smp_in;
        cof_q[k] <= cof_in[k];
      end
      {sa_q, sb_q, ad0_q, ad1_q} <= {a_signed, b_signed, add_lo, add_hi};
    end
  end

  assign chain_out = smp_q[3];

  function automatic logic signed [P-1:0] widen(input logic [W-1:0] v, input logic s);
    return {{(P-W){s & v[W-1]}}, v};
  endfunction

  logic signed [P-1:0] mul [4];
  always_comb
    for (int k = 0; k < 4; k++)
      mul[k] = widen(smp_q[k], sa_q) * widen(cof_q[k], sb_q);

  logic signed [P-1:0] mul_p [4];
  logic ad0_p, ad1_p;

  generate
    if (PIPE) begin : g_pipe
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int k = 0; k < 4; k++) mul_p[k] <= '0;
          {ad0_p, ad1_p} <= '0;
        end else if (en) begin
          for (int k = 0; k < 4; k++) mul_p[k] <= mul[k];
          {ad0_p, ad1_p} <= {ad0_q, ad1_q};
        end
      end
    end else begin : g_comb
      assign mul_p = mul;
      assign ad0_p = ad0_q;
      assign ad1_p = ad1_q;
    end
  endgenerate

  logic signed [P:0]   lvl_lo, lvl_hi;
  logic signed [S-1:0] total;

  assign lvl_lo = ad0_p ? ({mul_p[0][P-1], mul_p[0]} + {mul_p[1][P-1], mul_p[1]})
                        : ({mul_p[0][P-1], mul_p[0]} - {mul_p[1][P-1], mul_p[1]});
  assign lvl_hi = ad1_p ? ({mul_p[2][P-1], mul_p[2]} + {mul_p[3][P-1], mul_p[3]})
                        : ({mul_p[2][P-1], mul_p[2]} - {mul_p[3][P-1], mul_p[3]});
  assign total  = {lvl_lo[P], lvl_lo} + {lvl_hi[P], lvl_hi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sum_out <= '0;
    else if (en) sum_out <= total;
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) !rst_n |-> (sum_out == '0 && chain_out == '0)); // R1
  AST_TAP0_PAR: assert property (@(posedge clk) disable iff (!rst_n)
    en && !src_sel[0] |=> smp_q[0] == $past(smp_in)); // R2
  AST_TAP0_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    en && src_sel[0] |=> smp_q[0] == $past(chain_in)); // R2
  AST_TAP_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    en && src_sel[3] |=> chain_out == $past(smp_q[2])); // R3
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(sum_out) && $stable(chain_out)); // R9
endmodule

// File: tb/test_fir4_slice.sv
`timescale 1ns/1ps
module test_fir4_slice;
  localparam int W = 18;
  localparam bit PIPE = 1'b1;
  localparam int D = PIPE + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [W-1:0] smp_in = '0, chain_in = '0;
  logic [3:0] src_sel = '0;
  logic [W-1:0] coef0 = '0, coef1 = '0, coef2 = '0, coef3 = '0;
  logic a_signed = 1'b0, b_signed = 1'b0, add_lo = 1'b1, add_hi = 1'b1;
  logic [W-1:0] chain_out;
  logic [2*W+2:0] sum_out;

  fir4_slice #(.W(W), .PIPE(PIPE)) i_fir4_slice (
    .clk(clk), .rst_n(rst_n), .en(en), .smp_in(smp_in), .chain_in(chain_in),
    .src_sel(src_sel), .coef0(coef0), .coef1(coef1), .coef2(coef2), .coef3(coef3),
    .a_signed(a_signed), .b_signed(b_signed), .add_lo(add_lo), .add_hi(add_hi),
    .chain_out(chain_out), .sum_out(sum_out));

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] m_smp [4];
  longint hist [4];
  logic [31:0] seed = 32'h1234_5678;

  function automatic longint xv(input logic [W-1:0] v, input bit s);
    return s ? longint'($signed(v)) : longint'(v);
  endfunction

  function automatic logic [W-1:0] nextval(input int i);
    seed = seed * 32'd1103515245 + 32'd12345;
    case (i % 5)
      0: return 18'h20000;
      1: return 18'h3FFFF;
      2: return 18'h1FFFF;
      default: return seed[W+5:6];
    endcase
  endfunction

  task automatic check(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  // one clock: drive now (at a falling edge), update model, sample at next falling edge
  task automatic step();
    logic [W-1:0] nx [4];
    logic [W-1:0] cf [4];
    longint p [4];
    longint lo, hi;
    cf = '{coef0, coef1, coef2, coef3};
    if (en) begin
      for (int k = 0; k < 4; k++)
        nx[k] = src_sel[k] ? (k == 0 ? chain_in : m_smp[k-1]) : smp_in;   // R2 R3
      for (int k = 0; k < 4; k++) p[k] = xv(nx[k], a_signed) * xv(cf[k], b_signed); // R5
      lo = add_lo ? p[0] + p[1] : p[0] - p[1];   // R6
      hi = add_hi ? p[2] + p[3] : p[2] - p[3];
      for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = lo + hi;                          // R7
      m_smp = nx;
    end
    @(posedge clk);
    @(negedge clk);
    check(en ? "R8 sum_out latency/value" : "R9 sum_out held on stall",
          longint'($signed(sum_out)), hist[D]);
    check(en ? "R4 chain_out" : "R9 chain_out held on stall",
          longint'(chain_out), longint'(m_smp[3]));
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) begin m_smp[k] = '0; hist[k] = 0; end
    smp_in = 18'h12345; chain_in = 18'h2ABCD; coef0 = 18'h3FFFF; en = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 sum_out in reset", longint'(sum_out), 0);
    check("R1 chain_out in reset", longint'(chain_out), 0);
    rst_n = 1'b1;
    for (int cfg = 0; cfg < 16; cfg++) begin
      {a_signed, b_signed, add_lo, add_hi} = cfg[3:0];
      coef0 = nextval(cfg); coef1 = nextval(cfg + 1);
      coef2 = nextval(cfg + 2); coef3 = nextval(cfg + 3);
      for (int i = 0; i < 14; i++) begin
        en = 1'b1;
        smp_in = nextval(i);
        chain_in = nextval(i + 3);
        case (i)
          6: src_sel = 4'b0000;     // full parallel reload mid-stream
          8: src_sel = 4'b0101;     // mixed selects
          9: src_sel = 4'b1111;     // tap 0 from chain input
          10: begin src_sel = 4'b1010; en = 1'b0; end // stall with changed inputs
          default: src_sel = 4'b1110;
        endcase
        if (i == 12) coef1 = nextval(i + 7);
        step();
      end
    end
    // drain with zero inputs, all taps parallel
    smp_in = '0; src_sel = 4'b0000; en = 1'b1;
    repeat (4) step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule